// File: doc/BRIEF.md
# Passive Serial FPGA Configuration Loader

This block acts as the master that programs a target FPGA over a passive serial link. A start pulse latches the image length. The block then runs the request/status handshake. It pulls the active-low configuration request down until the target answers with its active-low status, waits, releases the request, and waits again until status returns high. Only then does it stream the image.

Image bytes arrive from a valid/ready source. Each byte is shifted out least significant bit first on a serial clock and data pair in SPI mode 0. After the image, ten all-zero bytes give the target 80 extra clocks to start up, and the serial clock then stays low. The block samples the synchronized config-done input for a bounded window. If done does not rise in that window, the whole attempt is repeated from the request step, up to a set number of retries. After the last failed retry the block parks in a permanent fail state.

A two-bit indicator code shows progress, alongside busy, done and fail flags.

Top module: `ps_cfg_loader`

## Requirements
- R1: After start, `cfg_req_no` goes low and stays low until the synchronized status reads low plus `SETTLE_CYC` cycles. It is then released high. No serial clock edge occurs while `cfg_req_no` is low, and none occurs before status has read high again and a further `SETTLE_CYC` cycles have passed.
- R2: `len_i` is latched on the start pulse, and exactly that many bytes are taken from the source. Each byte goes out with bit 0 first and bit 7 last.
- R3: Serial clock rules (SPI mode 0):
  - `sclk_o` idles low.
  - Each high phase and each low phase inside a byte lasts `CLK_DIV` system cycles.
  - `sdata_o` does not change while `sclk_o` is high.
- R4: After the image, exactly 80 further clocks are sent with `sdata_o` low. `sclk_o` then stays low.
- R5: `byte_ready_o` is high only while the shifter is empty and image bytes remain. A byte is accepted only on a cycle where `byte_valid_i` and `byte_ready_o` are both high. Gaps in `byte_valid_i` do not alter the bit stream.
- R6: If the two-flop-synchronized `cfg_done_i` reads high within `DONE_WIN` cycles after the last trailing clock, `done_o` goes high, `busy_o` goes low, and the indicator reads 3.
- R7: A missed done window restarts the sequence from the request-low step, for at most `MAX_RETRY` retries (4 attempts with default settings). After that, `fail_o` stays high, `cfg_req_no` stays high, and further start pulses are ignored until reset.
- R8: The indicator reads 0 when idle, 2 from the request step through the trailing clocks, 1 while waiting for done and in the fail state, and 3 after success.
- R9: After reset, the outputs are:
  - `cfg_req_no` = 1
  - `sclk_o`, `sdata_o`, `byte_ready_o`, `busy_o`, `done_o`, `fail_o` = 0
  - `ind_o` = 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle or after success |
| len_i | input | LEN_W | Image length in bytes, latched on start |
| byte_i | input | 8 | Image byte from the source |
| byte_valid_i | input | 1 | Source byte valid |
| byte_ready_o | output | 1 | Loader can accept a byte |
| cfg_req_no | output | 1 | Configuration request to target, active low |
| status_ni | input | 1 | Target status, active low, asynchronous |
| cfg_done_i | input | 1 | Target config-done, asynchronous |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |
| busy_o | output | 1 | Attempt in progress |
| done_o | output | 1 | Configuration succeeded |
| fail_o | output | 1 | All retries exhausted |
| ind_o | output | 2 | Progress indicator code |

## Verification
Two events can coincide in one cycle: the shifter finishing its eighth bit, and the byte source handshake for the next byte. The cycle the shifter goes empty is the first cycle ready can rise, so a source that is always valid lands its handshake right on that boundary. A second run inserts gaps in valid so the handshake arrives later instead. Both runs are judged by rebuilding every byte from the captured rising-edge bits and comparing it with the table. The bench also checks that ready never rises while the clock is high.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_REQ, ST_SET1, ST_REL, ST_SET2,
    ST_IMG, ST_TRL, ST_CHK, ST_OK, ST_FAIL
  } state_e;

  localparam logic [1:0] IND_IDLE = 2'd0;
  localparam logic [1:0] IND_WAIT = 2'd1;
  localparam logic [1:0] IND_RUN  = 2'd2;
  localparam logic [1:0] IND_OK   = 2'd3;
endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ps_timer.sv
module ps_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_o <= '0;
    else if (clr_i)            cnt_o <= '0;
    else if (cnt_o != '1)      cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ps_shifter.sv
module ps_shifter #(
  parameter int unsigned CLK_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       full_o,
  output logic       sclk_o,
  output logic       sdata_o
);
  localparam int unsigned DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [7:0]       sh_q;
  logic [2:0]       bit_q;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bit_q  <= '0;
      div_q  <= '0;
      full_o <= 1'b0;
      sclk_o <= 1'b0;
    end else if (load_i && !full_o) begin
      sh_q   <= data_i;
      bit_q  <= '0;
      div_q  <= '0;
      full_o <= 1'b1;
      sclk_o <= 1'b0;
    end else if (full_o) begin
      if (div_q == DIV_LAST) begin
        div_q  <= '0;
        sclk_o <= ~sclk_o;
        if (sclk_o) begin
          // falling edge: next bit, LSB first
          sh_q  <= sh_q >> 1;
          bit_q <= bit_q + 3'd1;
          if (bit_q == 3'd7) full_o <= 1'b0;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign sdata_o = full_o & sh_q[0];
endmodule

// File: rtl/ps_cfg_loader.sv
module ps_cfg_loader
  import ps_cfg_pkg::*;
#(
  parameter int unsigned LEN_W       = 24,
  parameter int unsigned CLK_DIV     = 11,
  parameter int unsigned SETTLE_CYC  = 3000,
  parameter int unsigned DONE_WIN    = 9000,
  parameter int unsigned MAX_RETRY   = 3,
  parameter int unsigned TRAIL_BYTES = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       byte_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  output logic             cfg_req_no,
  input  logic             status_ni,
  input  logic             cfg_done_i,
  output logic             sclk_o,
  output logic             sdata_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [1:0]       ind_o
);
  localparam int unsigned MAX_CNT = (SETTLE_CYC > DONE_WIN) ? SETTLE_CYC : DONE_WIN;
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);
  localparam int unsigned RTY_W   = $clog2(MAX_RETRY + 1);
  localparam int unsigned TRL_W   = $clog2(TRAIL_BYTES + 1);
  localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(DONE_WIN - 1);

  state_e           state_q, state_d;
  logic [LEN_W-1:0] len_q, remain_q;
  logic [TRL_W-1:0] trail_q;
  logic [RTY_W-1:0] retry_q;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       sync_q;
  logic             stat_n_s, done_s;
  logic             sh_full, sh_load, byte_hs, trl_load;
  logic [7:0]       sh_data;

  ps_sync #(.W(2), .RST_VAL(2'b01)) i_sync (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .d_i   ({cfg_done_i, status_ni}), .q_o(sync_q)
  );
  assign stat_n_s = sync_q[0];
  assign done_s   = sync_q[1];

  ps_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(state_d != state_q), .cnt_o(cnt)
  );

  assign byte_ready_o = (state_q == ST_IMG) && !sh_full && (remain_q != '0);
  assign byte_hs      = byte_ready_o && byte_valid_i;
  assign trl_load     = (state_q == ST_TRL) && !sh_full && (trail_q != '0);
  assign sh_load      = byte_hs || trl_load;
  assign sh_data      = (state_q == ST_TRL) ? 8'h00 : byte_i;

  ps_shifter #(.CLK_DIV(CLK_DIV)) i_shifter (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .load_i(sh_load), .data_i(sh_data),
    .full_o(sh_full), .sclk_o(sclk_o), .sdata_o(sdata_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_OK: if (start_i) state_d = ST_REQ;
      ST_REQ:  if (!stat_n_s) state_d = ST_SET1;
      ST_SET1: if (cnt == SET_LAST) state_d = ST_REL;
      ST_REL:  if (stat_n_s) state_d = ST_SET2;
      ST_SET2: if (cnt == SET_LAST) state_d = ST_IMG;
      ST_IMG:  if (remain_q == '0 && !sh_full) state_d = ST_TRL;
      ST_TRL:  if (trail_q == '0 && !sh_full) state_d = ST_CHK;
      ST_CHK: begin
        if (done_s) state_d = ST_OK;
        else if (cnt == WIN_LAST)
          state_d = (retry_q == RTY_W'(MAX_RETRY)) ? ST_FAIL : ST_REQ;
      end
      ST_FAIL: state_d = ST_FAIL;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      len_q    <= '0;
      remain_q <= '0;
      trail_q  <= '0;
      retry_q  <= '0;
    end else begin
      state_q <= state_d;
      if ((state_q == ST_IDLE || state_q == ST_OK) && start_i) begin
        len_q   <= len_i;
        retry_q <= '0;
      end
      if (state_q == ST_CHK && state_d == ST_REQ) retry_q <= retry_q + 1'b1;
      if (state_q == ST_SET2 && state_d == ST_IMG) begin
        remain_q <= len_q;
        trail_q  <= TRL_W'(TRAIL_BYTES);
      end
      if (byte_hs)  remain_q <= remain_q - 1'b1;
      if (trl_load) trail_q  <= trail_q - 1'b1;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_IDLE:          ind_o = IND_IDLE;
      ST_CHK, ST_FAIL:  ind_o = IND_WAIT;
      ST_OK:            ind_o = IND_OK;
      default:          ind_o = IND_RUN;
    endcase
  end

  assign cfg_req_no = !(state_q == ST_REQ || state_q == ST_SET1);
  assign busy_o     = !(state_q == ST_IDLE || state_q == ST_OK || state_q == ST_FAIL);
  assign done_o     = (state_q == ST_OK);
  assign fail_o     = (state_q == ST_FAIL);
endmodule

// File: rtl/ps_cfg_loader_chk.sv
module ps_cfg_loader_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_req_no,
  input logic       sclk_o,
  input logic       sdata_o,
  input logic       byte_ready_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       fail_o,
  input logic [1:0] ind_o
);
  assert_no_clk_in_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> cfg_req_no);

  assert_data_stable_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

  assert_ready_when_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> !sclk_o);

  assert_done_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ind_o == 2'd3 && !busy_o && !fail_o));

  assert_fail_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> (fail_o && cfg_req_no && !sclk_o));

  assert_busy_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (ind_o == 2'd1 || ind_o == 2'd2));

  assert_flags_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_o, done_o, fail_o}));
endmodule

bind ps_cfg_loader ps_cfg_loader_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_req_no(cfg_req_no),
  .sclk_o(sclk_o), .sdata_o(sdata_o), .byte_ready_o(byte_ready_o),
  .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o), .ind_o(ind_o)
);

// File: tb/test_ps_cfg_loader.sv
module test_ps_cfg_loader;
  localparam int LEN_W = 16, CLK_DIV = 2, SETTLE = 4, WIN = 40, MAX_RETRY = 3;
  localparam logic [7:0] IMG [8] = '{8'hA5, 8'h01, 8'h80, 8'h3C, 8'hF0, 8'h5A, 8'hC3, 8'h7E};
  // run vectors: {len, valid gaps, attempt on which done rises, expected attempts}
  localparam int RUNS [4][4] = '{'{4, 0, 1, 1}, '{0, 0, 1, 1}, '{6, 1, 1, 1}, '{3, 0, 2, 2}};

  logic clk = 0, rst_ni = 0, start_i = 0, byte_valid_i = 0, status_ni = 1, cfg_done_i = 0;
  logic [LEN_W-1:0] len_i = '0;
  logic [7:0] byte_i = '0;
  logic byte_ready_o, cfg_req_no, sclk_o, sdata_o, busy_o, done_o, fail_o;
  logic [1:0] ind_o;

  always #10 clk = ~clk;

  ps_cfg_loader #(.LEN_W(LEN_W), .CLK_DIV(CLK_DIV), .SETTLE_CYC(SETTLE),
                  .DONE_WIN(WIN), .MAX_RETRY(MAX_RETRY)) i_ps_cfg_loader (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .len_i(len_i),
    .byte_i(byte_i), .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o),
    .cfg_req_no(cfg_req_no), .status_ni(status_ni), .cfg_done_i(cfg_done_i),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .busy_o(busy_o), .done_o(done_o),
    .fail_o(fail_o), .ind_o(ind_o));

  int vectors = 0, fails = 0;
  bit rx_bits [4096];
  int rx_cnt = 0, att_base = 0, falls = 0, falls_base = 0;
  int src_len = 0, src_idx = 0, done_att = 0, dcnt = 0, scnt = 0, cyc = 0, hi_len = 0;
  bit src_gap = 0, hs_pend = 0, prev_req = 1, prev_sclk = 0, prev_sdata = 0;
  int hs_err = 0, mode_err = 0, r5_err = 0;

  // receiver: target samples on rising edge
  always @(posedge sclk_o) begin
    if (rx_cnt < 4096) rx_bits[rx_cnt] = sdata_o;
    rx_cnt++;
    if (!cfg_req_no || !status_ni) hs_err++;
  end

  // target and byte source model
  always @(negedge clk) begin
    cyc++;
    if (prev_req && !cfg_req_no) begin
      falls++; att_base = rx_cnt; src_idx = 0; dcnt = 0; hs_pend = 0;
    end
    prev_req = cfg_req_no;
    if (hs_pend) src_idx++;
    byte_valid_i = (src_idx < src_len) && (!src_gap || (cyc % 3 == 0));
    byte_i = IMG[src_idx % 8];
    hs_pend = byte_valid_i && byte_ready_o;
    if (!cfg_req_no) begin status_ni = 0; scnt = 0; end
    else if (scnt < 6) scnt++;
    else status_ni = 1;
    if (done_att != 0 && cfg_req_no && (falls - falls_base >= done_att) &&
        (rx_cnt - att_base >= src_len * 8 + 80)) dcnt++;
    cfg_done_i = (dcnt >= 10);
    if (byte_ready_o && sclk_o) r5_err++;
    if (sclk_o && prev_sclk && sdata_o != prev_sdata) mode_err++;
    if (sclk_o) hi_len++;
    else begin
      if (prev_sclk && hi_len != CLK_DIV) mode_err++;
      hi_len = 0;
    end
    prev_sclk = sclk_o; prev_sdata = sdata_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input int len);
    @(negedge clk);
    len_i = LEN_W'(len); start_i = 1;
    @(negedge clk);
    start_i = 0; len_i = '1;  // R2: later changes must not matter
  endtask

  task automatic do_run(input int len, input bit gap, input int datt, input int exp_att);
    int ones, idle_bad;
    @(negedge clk);
    src_len = len; src_gap = gap; done_att = datt; falls_base = falls;
    pulse_start(len);
    for (int t = 0; t < 3000 && !sclk_o; t++) @(negedge clk);
    chk(ind_o == 2'd2 && busy_o, "R8 running code", ind_o, 2);
    for (int t = 0; t < 20000 && !(done_o || fail_o); t++) @(negedge clk);
    chk(falls - falls_base == exp_att, "R7 attempts", falls - falls_base, exp_att);
    chk(done_o && !busy_o, "R6 done", done_o, 1);
    chk(ind_o == 2'd3, "R8 success code", ind_o, 3);
    chk(rx_cnt - att_base == len * 8 + 80, "R4 clock count", rx_cnt - att_base, len * 8 + 80);
    for (int k = 0; k < len; k++) begin
      logic [7:0] got;
      for (int j = 0; j < 8; j++) got[j] = rx_bits[att_base + 8 * k + j];
      chk(got == IMG[k % 8], "R2 byte LSB first", got, IMG[k % 8]);
    end
    ones = 0;
    for (int b = 0; b < 80; b++) ones += rx_bits[att_base + len * 8 + b];
    chk(ones == 0, "R4 trailing zeros", ones, 0);
    chk(hs_err == 0, "R1 handshake order", hs_err, 0);
    chk(mode_err == 0, "R3 clock mode", mode_err, 0);
    chk(r5_err == 0, "R5 ready only when empty", r5_err, 0);
    idle_bad = 0;
    for (int t = 0; t < 20; t++) begin @(negedge clk); idle_bad += sclk_o; end
    chk(idle_bad == 0, "R4 clock held idle", idle_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(cfg_req_no && !sclk_o && !sdata_o && !byte_ready_o, "R9 reset pins", cfg_req_no, 1);
    chk(!busy_o && !done_o && !fail_o && ind_o == 2'd0, "R9 reset flags", ind_o, 0);
    rst_ni = 1;
    repeat (3) @(negedge clk);

    for (int r = 0; r < 4; r++) do_run(RUNS[r][0], RUNS[r][1] != 0, RUNS[r][2], RUNS[r][3]);

    // R7 / R8: done never rises
    @(negedge clk);
    src_len = 2; src_gap = 0; done_att = 0; falls_base = falls;
    pulse_start(2);
    for (int t = 0; t < 5000 && !(rx_cnt - att_base == 96 && falls - falls_base == 1); t++)
      @(negedge clk);
    repeat (2 * CLK_DIV + 3) @(negedge clk);
    chk(ind_o == 2'd1 && busy_o && !done_o, "R8 waiting code", ind_o, 1);
    for (int t = 0; t < 20000 && !fail_o; t++) @(negedge clk);
    chk(falls - falls_base == MAX_RETRY + 1, "R7 retry count", falls - falls_base, MAX_RETRY + 1);
    chk(fail_o && !done_o && ind_o == 2'd1, "R7 fail flag", fail_o, 1);
    f0 = falls;
    pulse_start(2);
    repeat (40) @(negedge clk);
    chk(fail_o && cfg_req_no && falls == f0, "R7 start ignored after fail", falls - f0, 0);

    rst_ni = 0;
    @(negedge clk);
    chk(!fail_o && cfg_req_no && ind_o == 2'd0, "R9 reset clears fail", fail_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule